// File: doc/BRIEF.md
# Codec-side serial audio frame interface

This block sits at the digital edge of an audio codec and terminates a time-division serial link. The link has a shared bit clock, a frame marker from the controller, one serial line from the controller to the codec and one line back. A frame is 256 bit clocks long. It opens with a 16-bit tag slot, followed by twelve 20-bit data slots, each sent most significant bit first.

On the receive side the block splits each outbound frame into its slots. It reports which slots the tag marks as valid, and it hands register write and read commands to an external register file. It also passes valid audio slots on as strobed words. On the transmit side it builds the returned frame. That frame carries a ready flag, tags for a pending register read reply, and optional capture samples. Holding the frame marker high for an unusually long time restarts frame timing without clearing anything that has been latched. A test input floats the serial output and the forwarded bit clock.

Top module: `acl_codec_if`

## Requirements
- R1: While `rst_n` is low, and from then until the first frame, `ser_tx` is 0. In that state `slot_valid`, `reg_wr`, `reg_rd`, `pcm_stb`, `reg_addr` and `reg_wdata` are all zero.
- R2: A frame starts at the first rising `bclk` edge that samples `frame_mark` high after it was sampled low. The bit launched on `ser_tx` at that edge is the ready flag, taken from `core_ready` (1 = ready for register transfers).
- R3: A frame is laid out as a 16-bit tag slot followed by slots 1 to 12 of 20 bits each, 256 bits in all, MSB first. `ser_rx` is sampled on the falling `bclk` edge, and `ser_tx` changes on the rising edge.
- R4: After the tag slot has been received, `slot_valid[s-1]` equals tag bit 15 (frame valid) ANDed with tag bit 15-s, for slots s = 1..12. The value holds until the next tag slot.
- R5: Slot 1 bit 19 is the direction (0 = write), and bits 18:12 hold the register index. Slot 2 bits 19:4 hold the write data. A write with slots 1 and 2 both tagged valid gives exactly one `reg_wr` pulse with `reg_addr` and `reg_wdata`. `reg_wr` and `reg_rd` are never high together.
- R6: A slot whose tag bit is clear, or any slot of a frame whose frame-valid bit is clear, causes no strobe and leaves `reg_addr` and `reg_wdata` unchanged.
- R7: A read (slot 1 bit 19 = 1, slot 1 tagged) gives one `reg_rd` pulse, and `reg_rdata` is taken in the following cycle. The next returned frame sets tag bits 14 and 13. That frame carries the index in slot 1 bits 18:12 and the data in slot 2 bits 19:4.
- R8: Each tagged slot from 3 to 12 gives one `pcm_stb` pulse, with `pcm_slot` set to the slot number and `pcm_data` holding its 20 bits.
- R9: If `cap_valid` is high at a frame start, that returned frame carries `cap_left` in slot 3 and `cap_right` in slot 4, and sets tag bits 12 and 11. Otherwise those slots and bits are 0.
- R10: `frame_mark` sampled high on WARM_CYC consecutive edges (default 20) ends frame timing. `ser_tx` then drives 0 and no further slot is decoded. Latched outputs keep their values, and the next rising mark starts a normal frame.
- R11: While `test_hiz` is high, `ser_tx` and `clk_out` are high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Shared serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mark | input | 1 | Frame start marker from the controller |
| ser_rx | input | 1 | Serial data from controller to codec |
| test_hiz | input | 1 | Floats the link outputs when high |
| core_ready | input | 1 | Codec core ready for register transfers |
| reg_rdata | input | 16 | Register file read data for `reg_addr` |
| cap_valid | input | 1 | Capture samples present for the next frame |
| cap_left | input | 20 | Capture sample returned in slot 3 |
| cap_right | input | 20 | Capture sample returned in slot 4 |
| ser_tx | output | 1 | Serial data from codec to controller |
| clk_out | output | 1 | Forwarded bit clock, floated in test mode |
| slot_valid | output | 12 | Valid flags of received slots 1..12 |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 7 | Register index |
| reg_wdata | output | 16 | Register write data |
| pcm_stb | output | 1 | Valid audio slot received |
| pcm_slot | output | 4 | Number of that slot |
| pcm_data | output | 20 | Content of that slot |

## Verification
Some properties are checked on every cycle. Write and read strobes never coincide, and a write strobe lasts one cycle. An audio strobe only ever names a slot that the current tag flagged. Frame timing ends naturally only after slot 12, and a warm restart silences the serial output at once. The first bit after a frame start always equals the ready input. Other behaviour needs the bench's frames: the bit positions of commands and data, the ignoring of untagged slots, the read reply in the following frame, the returned capture samples, and the register contents surviving a warm restart.

// File: rtl/acl_pkg.sv
package acl_pkg;
  localparam int NSLOT   = 12;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int IDX_W   = 7;
  localparam int DAT_W   = 16;
  localparam int SLOT_CW = $clog2(NSLOT + 2);
  localparam int BIT_CW  = $clog2(SLOT_W);

  typedef logic [SLOT_CW-1:0] slot_t;
  typedef logic [BIT_CW-1:0]  bitpos_t;

  // slot number used while no frame is running
  localparam slot_t SLOT_IDLE = slot_t'(NSLOT + 1);

  function automatic bitpos_t last_bit(input slot_t s);
    return (s == '0) ? bitpos_t'(TAG_W - 1) : bitpos_t'(SLOT_W - 1);
  endfunction
endpackage

// File: rtl/acl_frame_timer.sv
module acl_frame_timer
  import acl_pkg::*;
#(
  parameter int WARM_CYC = 20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mark,
  output slot_t   slot_q,
  output bitpos_t bit_q,
  output slot_t   slot_d,
  output bitpos_t bit_d,
  output logic    rise,
  output logic    warm
);
  localparam int HC_W = $clog2(WARM_CYC + 1);

  logic            mark_q;
  logic [HC_W-1:0] hi_q, hi_d;

  always_comb begin
    rise = mark & ~mark_q;
    warm = mark && (hi_q == HC_W'(WARM_CYC - 1));
    if (!mark)                       hi_d = '0;
    else if (hi_q == HC_W'(WARM_CYC)) hi_d = hi_q;
    else                             hi_d = hi_q + 1'b1;

    slot_d = slot_q;
    bit_d  = bit_q;
    if (rise) begin
      slot_d = '0;
      bit_d  = '0;
    end else if (warm) begin
      slot_d = SLOT_IDLE;
      bit_d  = '0;
    end else if (slot_q != SLOT_IDLE) begin
      if (bit_q == last_bit(slot_q)) begin
        bit_d  = '0;
        slot_d = slot_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= 1'b0;
      hi_q   <= '0;
      slot_q <= SLOT_IDLE;
      bit_q  <= '0;
    end else begin
      mark_q <= mark;
      hi_q   <= hi_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  // R10
  warm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |=> (slot_q == SLOT_IDLE));

  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SLOT_IDLE && $past(slot_q) != SLOT_IDLE && !$past(warm))
      |-> ($past(slot_q) == slot_t'(NSLOT)));
endmodule

// File: rtl/acl_rx_deframe.sv
module acl_rx_deframe
  import acl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_rx,
  input  slot_t              slot_q,
  input  bitpos_t            bit_q,
  output logic [NSLOT-1:0]   slot_valid,
  output logic               reg_wr,
  output logic               reg_rd,
  output logic [IDX_W-1:0]   reg_addr,
  output logic [DAT_W-1:0]   reg_wdata,
  output logic               pcm_stb,
  output slot_t              pcm_slot,
  output logic [SLOT_W-1:0]  pcm_data
);
  logic              rx_q;
  logic [SLOT_W-1:0] sh_q, sh_d, word, cmd_q, cmd_d;
  logic [NSLOT-1:0]  valid_d;
  logic              wr_d, rd_d, stb_d, active, at_last, tag_ok;
  logic [IDX_W-1:0]  addr_d;
  logic [DAT_W-1:0]  wdata_d;
  slot_t             pslot_d;
  logic [SLOT_W-1:0] pdata_d;

  // controller data is sampled on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b0;
    else        rx_q <= ser_rx;
  end

  always_comb begin
    active  = (slot_q != SLOT_IDLE);
    at_last = active && (bit_q == last_bit(slot_q));
    word    = {sh_q[SLOT_W-2:0], rx_q};
    sh_d    = active ? word : sh_q;
    tag_ok  = |(slot_valid & (NSLOT'(1) << (slot_q - 1'b1)));

    valid_d = slot_valid;
    cmd_d   = cmd_q;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    stb_d   = 1'b0;
    addr_d  = reg_addr;
    wdata_d = reg_wdata;
    pslot_d = pcm_slot;
    pdata_d = pcm_data;

    if (at_last) begin
      if (slot_q == '0) begin
        for (int s = 1; s <= NSLOT; s++)
          valid_d[s-1] = word[TAG_W-1] & word[TAG_W-1-s];
      end else if (slot_q == slot_t'(1)) begin
        cmd_d = word;
      end else if (slot_q == slot_t'(2)) begin
        if (slot_valid[0]) begin
          if (cmd_q[SLOT_W-1]) begin
            rd_d   = 1'b1;
            addr_d = cmd_q[SLOT_W-2 -: IDX_W];
          end else if (slot_valid[1]) begin
            wr_d    = 1'b1;
            addr_d  = cmd_q[SLOT_W-2 -: IDX_W];
            wdata_d = word[SLOT_W-1 -: DAT_W];
          end
        end
      end else if (tag_ok) begin
        stb_d   = 1'b1;
        pslot_d = slot_q;
        pdata_d = word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      cmd_q      <= '0;
      slot_valid <= '0;
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      pcm_stb    <= 1'b0;
      pcm_slot   <= '0;
      pcm_data   <= '0;
    end else begin
      sh_q       <= sh_d;
      cmd_q      <= cmd_d;
      slot_valid <= valid_d;
      reg_wr     <= wr_d;
      reg_rd     <= rd_d;
      reg_addr   <= addr_d;
      reg_wdata  <= wdata_d;
      pcm_stb    <= stb_d;
      pcm_slot   <= pslot_d;
      pcm_data   <= pdata_d;
    end
  end

  // R5
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R8
  pcm_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_stb |-> |(slot_valid & (NSLOT'(1) << (pcm_slot - 1'b1))));
endmodule

// File: rtl/acl_tx_framer.sv
module acl_tx_framer
  import acl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  slot_t             slot_d,
  input  bitpos_t           bit_d,
  input  logic              ready,
  input  logic              reg_rd,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [DAT_W-1:0]  reg_rdata,
  input  logic              cap_valid,
  input  logic [SLOT_W-1:0] cap_left,
  input  logic [SLOT_W-1:0] cap_right,
  output logic              tx_q
);
  logic              pend_q, pend_d, rep_q, rep_d, capv_q, capv_d, tx_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DAT_W-1:0]  dat_q, dat_d;
  logic [SLOT_W-1:0] capl_q, capl_d, capr_q, capr_d, w, wsh;
  logic [TAG_W-1:0]  tag;

  always_comb begin
    pend_d = pend_q;
    idx_d  = idx_q;
    dat_d  = dat_q;
    rep_d  = rep_q;
    capv_d = capv_q;
    capl_d = capl_q;
    capr_d = capr_q;
    if (reg_rd) begin
      pend_d = 1'b1;
      idx_d  = reg_addr;
      dat_d  = reg_rdata;
    end else if (rise) begin
      pend_d = 1'b0;
    end
    if (rise) begin
      rep_d  = pend_q;
      capv_d = cap_valid;
      capl_d = cap_left;
      capr_d = cap_right;
    end

    tag = {ready, rep_q, rep_q, capv_q, capv_q, {(TAG_W-5){1'b0}}};
    if (slot_d == '0)
      w = {tag, {(SLOT_W-TAG_W){1'b0}}};
    else if (slot_d == slot_t'(1))
      w = rep_q ? {1'b0, idx_q, {(SLOT_W-1-IDX_W){1'b0}}} : '0;
    else if (slot_d == slot_t'(2))
      w = rep_q ? {dat_q, {(SLOT_W-DAT_W){1'b0}}} : '0;
    else if (slot_d == slot_t'(3))
      w = capv_q ? capl_q : '0;
    else if (slot_d == slot_t'(4))
      w = capv_q ? capr_q : '0;
    else
      w = '0;
    wsh  = w << bit_d;
    tx_d = (slot_d == SLOT_IDLE) ? 1'b0 : wsh[SLOT_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
      dat_q  <= '0;
      rep_q  <= 1'b0;
      capv_q <= 1'b0;
      capl_q <= '0;
      capr_q <= '0;
      tx_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      idx_q  <= idx_d;
      dat_q  <= dat_d;
      rep_q  <= rep_d;
      capv_q <= capv_d;
      capl_q <= capl_d;
      capr_q <= capr_d;
      tx_q   <= tx_d;
    end
  end

  // R2
  ready_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (tx_q == $past(ready)));
endmodule

// File: rtl/acl_codec_if.sv
module acl_codec_if
  import acl_pkg::*;
#(
  parameter int WARM_CYC = 20
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              frame_mark,
  input  logic              ser_rx,
  input  logic              test_hiz,
  input  logic              core_ready,
  input  logic [DAT_W-1:0]  reg_rdata,
  input  logic              cap_valid,
  input  logic [SLOT_W-1:0] cap_left,
  input  logic [SLOT_W-1:0] cap_right,
  output logic              ser_tx,
  output logic              clk_out,
  output logic [NSLOT-1:0]  slot_valid,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [IDX_W-1:0]  reg_addr,
  output logic [DAT_W-1:0]  reg_wdata,
  output logic              pcm_stb,
  output logic [SLOT_CW-1:0] pcm_slot,
  output logic [SLOT_W-1:0] pcm_data
);
  logic [1:0] rst_sync_q;
  logic       srst_n;
  slot_t      slot_q, slot_d;
  bitpos_t    bit_q, bit_d;
  logic       rise, warm, tx_q;

  // asynchronous assertion, release on the clock
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  acl_frame_timer #(.WARM_CYC(WARM_CYC)) u_timer (
    .clk(bclk), .rst_n(srst_n), .mark(frame_mark),
    .slot_q(slot_q), .bit_q(bit_q), .slot_d(slot_d), .bit_d(bit_d),
    .rise(rise), .warm(warm)
  );

  acl_rx_deframe u_rx (
    .clk(bclk), .rst_n(srst_n), .ser_rx(ser_rx),
    .slot_q(slot_q), .bit_q(bit_q),
    .slot_valid(slot_valid), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pcm_stb(pcm_stb), .pcm_slot(pcm_slot), .pcm_data(pcm_data)
  );

  acl_tx_framer u_tx (
    .clk(bclk), .rst_n(srst_n), .rise(rise),
    .slot_d(slot_d), .bit_d(bit_d), .ready(core_ready),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .cap_valid(cap_valid), .cap_left(cap_left), .cap_right(cap_right),
    .tx_q(tx_q)
  );

  assign ser_tx  = test_hiz ? 1'bz : tx_q;
  assign clk_out = test_hiz ? 1'bz : bclk;

  // R11
  drive_known_chk: assert property (@(posedge bclk) disable iff (!srst_n)
    !test_hiz |-> !$isunknown(ser_tx));

  // R10
  warm_quiet_chk: assert property (@(posedge bclk) disable iff (!srst_n)
    warm |=> !tx_q);
endmodule

// File: tb/acl_codec_if_test.sv
`timescale 1ns/1ps
module acl_codec_if_test;
  localparam int CLK_P = 82;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_mark = 1'b0;
  logic        ser_rx = 1'b0;
  logic        test_hiz = 1'b0;
  logic        core_ready = 1'b0;
  logic [15:0] reg_rdata;
  logic        cap_valid = 1'b0;
  logic [19:0] cap_left = '0;
  logic [19:0] cap_right = '0;
  logic        ser_tx, clk_out, reg_wr, reg_rd, pcm_stb;
  logic [11:0] slot_valid;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [3:0]  pcm_slot;
  logic [19:0] pcm_data;

  acl_codec_if uut (
    .bclk(bclk), .rst_n(rst_n), .frame_mark(frame_mark), .ser_rx(ser_rx),
    .test_hiz(test_hiz), .core_ready(core_ready), .reg_rdata(reg_rdata),
    .cap_valid(cap_valid), .cap_left(cap_left), .cap_right(cap_right),
    .ser_tx(ser_tx), .clk_out(clk_out), .slot_valid(slot_valid),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pcm_stb(pcm_stb), .pcm_slot(pcm_slot),
    .pcm_data(pcm_data)
  );

  always #(CLK_P/2) bclk = ~bclk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // register file model
  logic [15:0] regs [0:127];
  initial for (int i = 0; i < 128; i++) regs[i] = '0;
  always @(posedge bclk) if (reg_wr) regs[reg_addr] <= reg_wdata;
  assign reg_rdata = regs[reg_addr];

  // scoreboard: kind 0 write, 1 read, 2 audio slot
  typedef struct packed {
    logic [1:0]  kind;
    logic [6:0]  key;
    logic [19:0] data;
  } ev_t;
  ev_t exp_q[$];
  int  seen = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] kind, input logic [6:0] key,
                          input logic [19:0] data);
    exp_q.push_back('{kind, key, data});
  endtask

  // monitor
  always @(negedge bclk) begin
    if (rst_n && (reg_wr || reg_rd || pcm_stb)) begin
      ev_t got, want;
      seen++;
      if (reg_wr)      got = '{2'd0, reg_addr, {4'h0, reg_wdata}};
      else if (reg_rd) got = '{2'd1, reg_addr, 20'h0};
      else             got = '{2'd2, {3'b0, pcm_slot}, pcm_data};
      if (exp_q.size() == 0) begin
        chk("R6", "unexpected strobe", {3'b0, got}, 32'h0);
      end else begin
        want = exp_q.pop_front();
        // R5 R7 R8
        chk("R5/R7/R8", "strobe content", {3'b0, got}, {3'b0, want});
      end
    end
  end

  logic [15:0]  tagv;
  logic [19:0]  sl [1:12];
  logic [255:0] in_frame;

  task automatic idle(input int n);
    repeat (n) @(posedge bclk);
    #1;
  endtask

  task automatic clear_slots();
    tagv = '0;
    for (int s = 1; s <= 12; s++) sl[s] = '0;
  endtask

  // R3: drives one outbound frame and records the returned one
  task automatic send_frame(input int mark_len);
    logic [255:0] of;
    of = '0;
    of[255:240] = tagv;
    for (int s = 1; s <= 12; s++) of[239 - 20*(s-1) -: 20] = sl[s];
    frame_mark = 1'b1;
    @(posedge bclk); #1;
    for (int k = 0; k < 256; k++) begin
      ser_rx = of[255-k];
      frame_mark = (k + 1 < mark_len);
      @(negedge bclk);
      in_frame[255-k] = ser_tx;
      @(posedge bclk); #1;
    end
    ser_rx = 1'b0;
    frame_mark = 1'b0;
  endtask

  function automatic logic [19:0] in_slot(input int s);
    return in_frame[239 - 20*(s-1) -: 20];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int seen0;
    clear_slots();
    // R1 reset state
    idle(5);
    @(negedge bclk);
    chk("R1", "ser_tx in reset", {31'b0, ser_tx}, 0);
    chk("R1", "strobes in reset", {29'b0, reg_wr, reg_rd, pcm_stb}, 0);
    chk("R1", "slot_valid in reset", {20'b0, slot_valid}, 0);
    @(posedge bclk); #1;
    rst_n = 1'b1;
    idle(4);
    @(negedge bclk);
    chk("R1", "ser_tx idle after reset", {31'b0, ser_tx}, 0);
    @(posedge bclk); #1;

    // R2 not ready
    send_frame(16);
    chk("R2", "ready flag low", {31'b0, in_frame[255]}, 0);

    // R5 write, R2 ready, R4 tags
    core_ready = 1'b1;
    clear_slots();
    tagv  = 16'hE000;
    sl[1] = {1'b0, 7'h15, 12'h0};
    sl[2] = {16'hBEEF, 4'h0};
    push_exp(2'd0, 7'h15, 20'h0BEEF);
    send_frame(16);
    idle(3);
    chk("R2", "ready flag high", {31'b0, in_frame[255]}, 1);
    chk("R4", "slot_valid write frame", {20'b0, slot_valid}, 32'h003);
    chk("R5", "write consumed", exp_q.size(), 0);

    // R8 audio slots, R6 untagged slot 5 ignored
    clear_slots();
    tagv  = 16'h8000 | 16'h1000 | 16'h0100 | 16'h0008;
    sl[3] = 20'hA1234; sl[5] = 20'h12345; sl[7] = 20'h5A5A5; sl[12] = 20'hFFFFF;
    push_exp(2'd2, 7'd3, 20'hA1234);
    push_exp(2'd2, 7'd7, 20'h5A5A5);
    push_exp(2'd2, 7'd12, 20'hFFFFF);
    send_frame(16);
    idle(3);
    chk("R4", "slot_valid audio frame", {20'b0, slot_valid}, 32'h844);
    chk("R8", "audio strobes consumed", exp_q.size(), 0);

    // R6 frame-valid clear: nothing happens
    clear_slots();
    seen0 = seen;
    tagv  = 16'h7FF8;
    sl[1] = {1'b0, 7'h20, 12'h0};
    sl[2] = {16'h1234, 4'h0};
    sl[3] = 20'h77777;
    send_frame(16);
    idle(3);
    chk("R6", "no strobe without frame valid", seen - seen0, 0);
    chk("R6", "slot_valid all clear", {20'b0, slot_valid}, 0);
    chk("R6", "reg_addr kept", {25'b0, reg_addr}, 32'h15);

    // R6 slot 2 untagged: write ignored
    tagv = 16'hC000;
    send_frame(16);
    idle(3);
    chk("R6", "no write with slot 2 untagged", seen - seen0, 0);
    chk("R6", "reg_wdata kept", {16'b0, reg_wdata}, 32'hBEEF);

    // R7 read and reply in next frame
    clear_slots();
    tagv  = 16'hC000;
    sl[1] = {1'b1, 7'h15, 12'h0};
    push_exp(2'd1, 7'h15, 20'h0);
    send_frame(16);
    clear_slots();
    send_frame(16);
    chk("R7", "reply tag bits", {30'b0, in_frame[254:253]}, 3);
    chk("R7", "reply index slot", {12'b0, in_slot(1)}, {12'b0, 1'b0, 7'h15, 12'h0});
    chk("R7", "reply data slot", {12'b0, in_slot(2)}, 32'hBEEF0);
    send_frame(16);
    chk("R7", "reply only once", {30'b0, in_frame[254:253]}, 0);

    // R9 capture samples
    cap_valid = 1'b1; cap_left = 20'h13579; cap_right = 20'h2468A;
    send_frame(16);
    chk("R9", "capture tag bits", {30'b0, in_frame[252:251]}, 3);
    chk("R9", "capture left", {12'b0, in_slot(3)}, 32'h13579);
    chk("R9", "capture right", {12'b0, in_slot(4)}, 32'h2468A);
    cap_valid = 1'b0;
    send_frame(16);
    chk("R9", "capture absent", {12'b0, in_slot(3)}, 0);

    // R10 long mark in the middle of a write frame
    seen0 = seen;
    tagv  = 16'hE000;
    sl[1] = {1'b0, 7'h40, 12'h0};
    sl[2] = {16'h5555, 4'h0};
    send_frame(30);
    idle(3);
    chk("R10", "frame stopped, no write", seen - seen0, 0);
    chk("R10", "returned frame silent after restart", {31'b0, |in_frame[200:0]}, 0);
    chk("R10", "reg_addr kept", {25'b0, reg_addr}, 32'h15);
    chk("R10", "reg_wdata kept", {16'b0, reg_wdata}, 32'hBEEF);
    sl[1] = {1'b0, 7'h33, 12'h0};
    sl[2] = {16'h0C0D, 4'h0};
    push_exp(2'd0, 7'h33, 20'h00C0D);
    send_frame(16);
    idle(3);
    chk("R10", "normal frame after restart", exp_q.size(), 0);

    // R11 test mode
    test_hiz = 1'b1;
    idle(2);
    @(negedge bclk);
    chk("R11", "ser_tx floated", {31'b0, ser_tx === 1'bz}, 1);
    chk("R11", "clk_out floated", {31'b0, clk_out === 1'bz}, 1);
    @(posedge bclk); #1;
    test_hiz = 1'b0;
    idle(1);
    @(negedge bclk);
    chk("R11", "ser_tx driven again", {31'b0, ser_tx === 1'bz}, 0);

    // R1 reset clears latched outputs
    rst_n = 1'b0;
    #1;
    chk("R1", "reg_addr cleared", {25'b0, reg_addr}, 0);
    chk("R1", "reg_wdata cleared", {16'b0, reg_wdata}, 0);
    chk("R1", "slot_valid cleared", {20'b0, slot_valid}, 0);
    idle(2);
    finish_run();
  end
endmodule